// File: doc/BRIEF.md
# Static Memory Decoder with Wait States

This block sits between a 32-bit processor bus and two static memory banks: a word-wide fast SRAM built from four byte-wide devices, and a slow ROM. Each cycle it looks at the request flag, the top address bit, the transfer size, the low address bits and the read/write flag. From these it selects a bank, drives that bank's chip and output enables, and produces one write strobe for each SRAM byte lane.

An SRAM access completes in a single clock cycle. A ROM access occupies the ROM bank for a fixed number of cycles, and the block holds the processor's wait line high for all but the last of them. When the processor runs an internal cycle that needs no memory, the block drops back to an idle decode state and raises no wait, so such cycles run at full speed. Reset puts the block on the ROM path, ready for the processor's first fetch from the boot region.

The outputs are all registered. The access attributes are captured on the edge that starts an access. While a ROM access is being stretched, the bus inputs are not sampled.

Top module: `stmem_ctrl`

## Requirements
- R1: While reset is active, and for four cycles after the synchronised release, rom_ce and rom_oe are 1 and mem_wait is 1 in all of those cycles except the last. An asynchronous reset asserted during any access puts the outputs into this state at once.
- R2: For an access started with cpu_int = 0, addr[31] = 1 selects the SRAM bank (ram_ce = 1) and addr[31] = 0 selects the ROM bank (rom_ce = 1).
- R3: An SRAM access raises ram_ce for the single cycle after the edge that decoded it, and it never raises mem_wait. Back-to-back SRAM accesses run one per cycle.
- R4: A ROM access raises rom_ce for four consecutive cycles. mem_wait is 1 in the first three of those cycles and 0 in the fourth.
- R5: With cpu_int = 1 at a decode point, the next cycle has every enable and strobe at 0 and mem_wait at 0.
- R6: An SRAM write with size = 2'b10 (word), or with the unused code size = 2'b11, drives ram_we = 4'b1111.
- R7: An SRAM write with size = 2'b01 (halfword) drives ram_we = 4'b0011 when addr[1] = 0 and 4'b1100 when addr[1] = 1.
- R8: An SRAM write with size = 2'b00 (byte) drives only ram_we bit addr[1:0].
- R9: An SRAM read (wr = 0) drives ram_oe = 1 and ram_we = 4'b0000. Whenever any bit of ram_we is 1, ram_oe is 0.
- R10: A write to the ROM region drives rom_ce with rom_oe = 0 and ram_we = 4'b0000, and it still takes the full ROM access length.
- R11: Changes on addr, size, wr or cpu_int during the later cycles of a ROM access do not affect any output until that access completes.
- R12: ram_ce and rom_ce are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cpu_int | input | 1 | 1 = internal processor cycle with no memory use, 0 = memory access |
| addr | input | 32 | Byte address of the access |
| size | input | 2 | Transfer size: 00 byte, 01 halfword, 10 word, 11 treated as word |
| wr | input | 1 | 1 = write, 0 = read |
| ram_ce | output | 1 | SRAM bank chip enable |
| ram_oe | output | 1 | Shared output enable for all four SRAM byte devices |
| ram_we | output | 4 | Per-byte-lane SRAM write strobes, bit n for byte address n mod 4 |
| rom_ce | output | 1 | ROM bank chip enable |
| rom_oe | output | 1 | ROM output enable |
| mem_wait | output | 1 | Stall request to the processor while ROM data is not yet valid |

## Verification
The hardest situation to reach from the ports is a ROM access whose bus inputs change while the access is still being stretched. A real processor holds its bus steady during a stall, so this only happens if the stimulus does it on purpose. The vector table therefore puts new RAM-write and internal-cycle patterns on the inputs during the ROM wait cycles, and it checks that the ROM enables, the wait line and the zero strobes stay exactly as the first cycle of the access set them. An asynchronous reset is also applied in the middle of an SRAM write to confirm that the block falls back onto the ROM path at once.

// File: rtl/stmem_pkg.sv
package stmem_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RAM  = 2'd1,
    ST_ROM  = 2'd2
  } stmem_state_e;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;

endpackage

// File: rtl/stmem_region_dec.sv
module stmem_region_dec (
  input  logic top_bit,
  input  logic cpu_int,
  input  logic wr,
  output logic go_ram,
  output logic go_rom,
  output logic ram_write
);

  // top address bit set = SRAM, clear = ROM
  always_comb begin
    go_ram    = ~cpu_int & top_bit;
    go_rom    = ~cpu_int & ~top_bit;
    ram_write = go_ram & wr;
  end

endmodule

// File: rtl/stmem_lane_gen.sv
module stmem_lane_gen #(
  parameter int LANES = 4,
  localparam int LB   = $clog2(LANES)
) (
  input  logic [LB-1:0]    addr_lo,
  input  logic [1:0]       size,
  output logic [LANES-1:0] lane_en
);

  import stmem_pkg::*;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [LB-1:0] GI = LB'(g);
    always_comb begin
      unique case (size)
        SZ_BYTE: lane_en[g] = (addr_lo == GI);
        SZ_HALF: lane_en[g] = (addr_lo[LB-1:1] == GI[LB-1:1]);
        default: lane_en[g] = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/stmem_wait_fsm.sv
module stmem_wait_fsm #(
  parameter int ROM_WAITS = 3,
  localparam int CW       = $clog2(ROM_WAITS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_int,
  input  logic go_ram,
  input  logic go_rom,
  output logic ready,
  output logic ram_act,
  output logic rom_act,
  output logic stall
);

  import stmem_pkg::*;

  stmem_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  // decode point: idle, SRAM, or last ROM cycle
  assign ready = (state_q != ST_ROM) || (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (ready) begin
      if (go_ram) begin
        state_d = ST_RAM;
      end else if (go_rom) begin
        state_d = ST_ROM;
        cnt_d   = CW'(ROM_WAITS);
      end else begin
        state_d = ST_IDLE;
      end
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ROM;
      cnt_q   <= CW'(ROM_WAITS);
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign ram_act = (state_q == ST_RAM);
  assign rom_act = (state_q == ST_ROM);
  assign stall   = rom_act && (cnt_q != '0);

  // R4
  rom_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> rom_act);

  // R4
  rom_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R5
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && cpu_int) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/stmem_ctrl.sv
module stmem_ctrl #(
  parameter int ADDR_W    = 32,
  parameter int LANES     = 4,
  parameter int ROM_WAITS = 3,
  localparam int LB       = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_int,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              wr,
  output logic              ram_ce,
  output logic              ram_oe,
  output logic [LANES-1:0]  ram_we,
  output logic              rom_ce,
  output logic              rom_oe,
  output logic              mem_wait
);

  // reset: asynchronous assert, synchronous release
  logic rst_m, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  logic addr_unused;
  assign addr_unused = ^addr[ADDR_W-2:LB];

  logic go_ram, go_rom, ram_write;
  stmem_region_dec u_dec (
    .top_bit   (addr[ADDR_W-1]),
    .cpu_int   (cpu_int),
    .wr        (wr),
    .go_ram    (go_ram),
    .go_rom    (go_rom),
    .ram_write (ram_write)
  );

  logic [LANES-1:0] lane_en;
  stmem_lane_gen #(.LANES(LANES)) u_lanes (
    .addr_lo (addr[LB-1:0]),
    .size    (size),
    .lane_en (lane_en)
  );

  logic ready, ram_act, rom_act, stall;
  stmem_wait_fsm #(.ROM_WAITS(ROM_WAITS)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_s),
    .cpu_int (cpu_int),
    .go_ram  (go_ram),
    .go_rom  (go_rom),
    .ready   (ready),
    .ram_act (ram_act),
    .rom_act (rom_act),
    .stall   (stall)
  );

  // access attributes, captured only at a decode point
  logic             wr_q, wr_d;
  logic [LANES-1:0] we_q, we_d;

  always_comb begin
    wr_d = wr_q;
    we_d = we_q;
    if (ready) begin
      wr_d = wr & ~cpu_int;
      we_d = lane_en & {LANES{ram_write}};
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      wr_q <= 1'b0;
      we_q <= '0;
    end else begin
      wr_q <= wr_d;
      we_q <= we_d;
    end
  end

  assign ram_ce   = ram_act;
  assign ram_oe   = ram_act & ~wr_q;
  assign ram_we   = we_q;
  assign rom_ce   = rom_act;
  assign rom_oe   = rom_act & ~wr_q;
  assign mem_wait = stall;

  // R9
  we_excl_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (ram_we != '0) |-> (ram_ce && !ram_oe));

  // R10
  rom_nowe_chk: assert property (@(posedge clk) disable iff (!rst_s)
    rom_ce |-> (ram_we == '0));

  // R11
  rom_stable_chk: assert property (@(posedge clk) disable iff (!rst_s)
    mem_wait |=> ($stable(rom_oe) && $stable(ram_we)));

  // R12
  bank_excl_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !(ram_ce && rom_ce));

  // R4
  wait_end_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $fell(mem_wait) |-> rom_ce);

endmodule

// File: tb/sim_stmem_ctrl.sv
module sim_stmem_ctrl;

  logic        clk;
  logic        rst_n;
  logic        cpu_int;
  logic [31:0] addr;
  logic [1:0]  size;
  logic        wr;
  logic        ram_ce, ram_oe, rom_ce, rom_oe, mem_wait;
  logic [3:0]  ram_we;

  int checks = 0;
  int fails  = 0;

  stmem_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cpu_int(cpu_int), .addr(addr), .size(size),
    .wr(wr), .ram_ce(ram_ce), .ram_oe(ram_oe), .ram_we(ram_we),
    .rom_ce(rom_ce), .rom_oe(rom_oe), .mem_wait(mem_wait)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic        ci;
    logic        w;
    logic [1:0]  sz;
    logic [31:0] a;
    logic        e_rce;
    logic        e_roe;
    logic        e_oce;
    logic        e_ooe;
    logic        e_wt;
    logic [3:0]  e_we;
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b1,2'b10,32'h8000_0000,1'b1,1'b0,1'b0,1'b0,1'b0,4'b1111,4'd6},  // R6 word
    '{1'b0,1'b1,2'b00,32'h8000_0001,1'b1,1'b0,1'b0,1'b0,1'b0,4'b0010,4'd8},  // R8
    '{1'b0,1'b1,2'b00,32'h8000_0003,1'b1,1'b0,1'b0,1'b0,1'b0,4'b1000,4'd8},  // R8
    '{1'b0,1'b1,2'b00,32'h8000_0000,1'b1,1'b0,1'b0,1'b0,1'b0,4'b0001,4'd8},  // R8
    '{1'b0,1'b1,2'b01,32'h8000_0002,1'b1,1'b0,1'b0,1'b0,1'b0,4'b1100,4'd7},  // R7 upper
    '{1'b0,1'b1,2'b01,32'h8000_0001,1'b1,1'b0,1'b0,1'b0,1'b0,4'b0011,4'd7},  // R7 lower
    '{1'b0,1'b1,2'b11,32'h8000_0001,1'b1,1'b0,1'b0,1'b0,1'b0,4'b1111,4'd6},  // R6 code 11
    '{1'b0,1'b0,2'b10,32'h8000_0004,1'b1,1'b1,1'b0,1'b0,1'b0,4'b0000,4'd9},  // R9
    '{1'b0,1'b0,2'b00,32'h8000_0007,1'b1,1'b1,1'b0,1'b0,1'b0,4'b0000,4'd9},  // R9
    '{1'b1,1'b1,2'b10,32'h8000_0000,1'b0,1'b0,1'b0,1'b0,1'b0,4'b0000,4'd5},  // R5
    '{1'b1,1'b0,2'b00,32'h0000_0000,1'b0,1'b0,1'b0,1'b0,1'b0,4'b0000,4'd5},  // R5
    '{1'b0,1'b0,2'b10,32'h0000_0010,1'b0,1'b0,1'b1,1'b1,1'b1,4'b0000,4'd4},  // R4 / R2 ROM
    '{1'b1,1'b1,2'b10,32'h8000_0000,1'b0,1'b0,1'b1,1'b1,1'b1,4'b0000,4'd11}, // R11
    '{1'b0,1'b1,2'b00,32'h8000_0001,1'b0,1'b0,1'b1,1'b1,1'b1,4'b0000,4'd11}, // R11
    '{1'b0,1'b1,2'b10,32'h8000_0000,1'b0,1'b0,1'b1,1'b1,1'b0,4'b0000,4'd4},  // R4 last
    '{1'b0,1'b1,2'b10,32'h8000_0008,1'b1,1'b0,1'b0,1'b0,1'b0,4'b1111,4'd2},  // R2 RAM
    '{1'b0,1'b1,2'b10,32'h0000_0004,1'b0,1'b0,1'b1,1'b0,1'b1,4'b0000,4'd10}, // R10
    '{1'b0,1'b1,2'b10,32'h8000_0000,1'b0,1'b0,1'b1,1'b0,1'b1,4'b0000,4'd11}, // R11
    '{1'b0,1'b0,2'b10,32'h8000_0000,1'b0,1'b0,1'b1,1'b0,1'b1,4'b0000,4'd11}, // R11
    '{1'b0,1'b1,2'b00,32'h8000_0002,1'b0,1'b0,1'b1,1'b0,1'b0,4'b0000,4'd10}, // R10
    '{1'b0,1'b0,2'b01,32'h0000_0002,1'b0,1'b0,1'b1,1'b1,1'b1,4'b0000,4'd4},  // R4
    '{1'b0,1'b0,2'b01,32'h0000_0002,1'b0,1'b0,1'b1,1'b1,1'b1,4'b0000,4'd4},  // R4
    '{1'b0,1'b0,2'b01,32'h0000_0002,1'b0,1'b0,1'b1,1'b1,1'b1,4'b0000,4'd4},  // R4
    '{1'b0,1'b0,2'b01,32'h0000_0002,1'b0,1'b0,1'b1,1'b1,1'b0,4'b0000,4'd4},  // R4
    '{1'b0,1'b0,2'b10,32'h8000_000C,1'b1,1'b1,1'b0,1'b0,1'b0,4'b0000,4'd3},  // R3
    '{1'b0,1'b0,2'b10,32'h8000_0010,1'b1,1'b1,1'b0,1'b0,1'b0,4'b0000,4'd3},  // R3
    '{1'b1,1'b0,2'b10,32'h0000_0000,1'b0,1'b0,1'b0,1'b0,1'b0,4'b0000,4'd5}   // R5
  };

  task automatic expect_out(input string req, input logic [8:0] exp);
    logic [8:0] act;
    act = {ram_ce, ram_oe, rom_ce, rom_oe, mem_wait, ram_we};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {ram_ce,ram_oe,rom_ce,rom_oe,wait,we} actual %b expected %b",
               req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; cpu_int = 1'b1; addr = '0; size = 2'b10; wr = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    expect_out("R1 in reset", 9'b0_0_1_1_1_0000);
    rst_n = 1'b1;
    // two sync edges, then three counted ROM cycles with wait high
    repeat (4) @(negedge clk);
    expect_out("R1 wait after release", 9'b0_0_1_1_1_0000);
    @(negedge clk);
    expect_out("R1 last boot ROM cycle", 9'b0_0_1_1_0_0000);

    for (int i = 0; i < NV; i++) begin
      cpu_int = TBL[i].ci; wr = TBL[i].w; size = TBL[i].sz; addr = TBL[i].a;
      @(negedge clk);
      expect_out($sformatf("R%0d row %0d", TBL[i].tag, i),
                 {TBL[i].e_rce, TBL[i].e_roe, TBL[i].e_oce, TBL[i].e_ooe,
                  TBL[i].e_wt, TBL[i].e_we});
      checks++;
      if (ram_ce && rom_ce) begin
        fails++;
        $display("FAIL R12 row %0d: actual both enables expected at most one", i);
      end
    end

    // R1 asynchronous reset in the middle of an SRAM write
    cpu_int = 1'b0; wr = 1'b1; size = 2'b10; addr = 32'h8000_0020;
    @(negedge clk);
    expect_out("R6 before reset", 9'b1_0_0_0_0_1111);
    #5 rst_n = 1'b0;
    #1 expect_out("R1 async reset", 9'b0_0_1_1_1_0000);
    @(negedge clk);
    rst_n = 1'b1; cpu_int = 1'b1;
    repeat (4) @(negedge clk);
    expect_out("R1 second release wait", 9'b0_0_1_1_1_0000);
    @(negedge clk);
    expect_out("R1 second release last", 9'b0_0_1_1_0_0000);
    @(negedge clk);
    expect_out("R5 idle after boot", 9'b0_0_0_0_0_0000);
    summary();
  end

endmodule